// File: doc/BRIEF.md
# Posted Register Write Tracker

This block carries register writes from a fast bus clock into a slower timer clock domain. Ten destination registers are reached through a holding register and a toggle handshake: a write is taken on the bus side at once, and the transfer to the timer domain finishes later. While a write to one of these registers is still on its way, that register's bit in a pending status word stays set. Software polls the status word before touching the same register again.

A control register on the bus side sets the mode. With posting on, which is the reset state, the bus never waits and the pending bits report the progress of each write. With posting off, a write to a destination register holds the bus ready low until the value has landed in the timer domain, and no pending bit is shown for it. The control register and the status word live in the bus domain. They are read and written with no crossing. The destination registers come out on the timer-domain side as a flat vector.

Top module: `posted_write_tracker`

## Requirements
- R1: After reset the pending word (address 11) reads 0, the interface control register (address 10) reads 0x4 so posting is on, and wrReady is high.
- R2: Addresses 0 to 9 select the destination registers. A write to address k sets pending bit k and no other bit.
- R3: In posted mode the pending bit of an accepted write already reads as set in the bus cycle after the accepting edge.
- R4: A pending bit clears only after the functional domain has loaded the written data into destination register k. At that point fnRegs slice k holds that data.
- R5: In posted mode a write to a destination register is accepted without a stall: wrReady stays high.
- R6: A write to a destination register whose pending bit is still set is dropped. The register keeps the earlier value and the pending bit clears at its normal time.
- R7: With bit 2 of the interface control register cleared, a write to a destination register holds wrReady low until the data has landed. The register's pending bit never reads as set during that write.
- R8: A write to address 10 takes effect on the accepting edge and reads back in the next cycle. Bit 2 of that register selects posted (1) or stalling (0) mode.
- R9: Address 11 is read-only. A write to it leaves the pending word unchanged and is accepted without a stall. Reads of addresses 0 to 9 return 0.
- R10: Several destination registers can be pending at once. Each clears on its own and each lands its own data.
- R11: A stalling-mode write to a register that is still pending from an earlier posted write waits for that bit to clear, then performs its own transfer and lands its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus-side clock |
| busRstN | input | 1 | Active-low asynchronous reset, bus domain |
| fnClk | input | 1 | Functional (timer) clock |
| fnRstN | input | 1 | Active-low asynchronous reset, functional domain |
| wrEn | input | 1 | Write request, held until wrReady is seen high at a clock edge |
| wrAddr | input | 4 | Write address: 0-9 destination, 10 interface control, 11 pending word |
| wrData | input | DATA_W | Write data |
| wrReady | output | 1 | Write accepted at the edge where wrEn and wrReady are both high |
| rdAddr | input | 4 | Read address |
| rdData | output | DATA_W | Combinational read data for rdAddr |
| fnRegs | output | 10*DATA_W | Destination registers in the functional domain, register k at slice k |

## Verification
The pending bit of a posted write is due in the first bus cycle after the accepting edge. The bench therefore reads the status word on the falling edge that follows that edge. Clearing takes two functional-clock flops plus one loading edge on the way out, and two bus-clock flops on the way back. Because the two clocks are unrelated, that delay varies, so the bench polls the status word on each falling bus edge with a bounded count and checks the landed data only after the bit has dropped. In stalling mode the bench samples wrReady shortly after each falling edge. It holds the request until wrReady is seen high, and checks the destination register on the next falling edge.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int NUM_POSTED  = 10;
  localparam int ADDR_W      = 4;
  localparam int IDX_IFCTRL  = 10;
  localparam int IDX_PENDING = 11;
  localparam int POST_EN_BIT = 2;

  typedef struct packed {
    logic [NUM_POSTED-1:0] launch;
    logic                  ifWr;
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} stallState_t;
endpackage

// File: rtl/pwt_sync2.sv
module pwt_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pwt_datapath.sv
module pwt_datapath
  import pwt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         busClk,
  input  logic                         busRstN,
  input  logic                         fnClk,
  input  logic                         fnRstN,
  input  strobe_t                      strobe,
  input  logic [DATA_W-1:0]            wrData,
  output logic [NUM_POSTED-1:0]        pendRaw,
  output logic [DATA_W-1:0]            ifCtrl,
  output logic [NUM_POSTED*DATA_W-1:0] fnRegs
);
  localparam logic [DATA_W-1:0] IFCTRL_RESET = DATA_W'(1) << POST_EN_BIT;

  logic [DATA_W-1:0]     hold [NUM_POSTED];
  logic [DATA_W-1:0]     dest [NUM_POSTED];
  logic [NUM_POSTED-1:0] reqTog;
  logic [NUM_POSTED-1:0] ackSync;
  logic [NUM_POSTED-1:0] reqSync;
  logic [NUM_POSTED-1:0] fnSeen;

  // bus domain: holding registers, request toggles, interface control
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      reqTog <= '0;
      ifCtrl <= IFCTRL_RESET;
      for (int i = 0; i < NUM_POSTED; i++) hold[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_POSTED; i++) begin
        if (strobe.launch[i]) begin
          hold[i]   <= wrData;
          reqTog[i] <= ~reqTog[i];
        end
      end
      if (strobe.ifWr) ifCtrl <= wrData;
    end
  end

  pwt_sync2 #(.WIDTH(NUM_POSTED)) reqSync_i (
    .clk(fnClk), .rstN(fnRstN), .d(reqTog), .q(reqSync)
  );

  pwt_sync2 #(.WIDTH(NUM_POSTED)) ackSync_i (
    .clk(busClk), .rstN(busRstN), .d(fnSeen), .q(ackSync)
  );

  // functional domain: land data when a new request toggle arrives
  always_ff @(posedge fnClk or negedge fnRstN) begin
    if (!fnRstN) begin
      fnSeen <= '0;
      for (int i = 0; i < NUM_POSTED; i++) dest[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_POSTED; i++) begin
        if (reqSync[i] != fnSeen[i]) begin
          dest[i]   <= hold[i];
          fnSeen[i] <= reqSync[i];
        end
      end
    end
  end

  assign pendRaw = reqTog ^ ackSync;

  for (genvar g = 0; g < NUM_POSTED; g++) begin : gRegOut
    assign fnRegs[g*DATA_W +: DATA_W] = dest[g];

    // R4: the holding value seen by the functional domain is steady while it is being landed
    assert_hold_stable_R4: assert property (@(posedge fnClk) disable iff (!fnRstN)
      (reqSync[g] != fnSeen[g]) |-> $stable(hold[g]));
  end

  // R6: the control never relaunches a register whose transfer is still open
  assert_launch_idle_R6: assert property (@(posedge busClk) disable iff (!busRstN)
    (strobe.launch & pendRaw) == '0);
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
  import pwt_pkg::*;
(
  input  logic                  busClk,
  input  logic                  busRstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [NUM_POSTED-1:0] pendRaw,
  input  logic                  postEn,
  output logic                  wrReady,
  output strobe_t               strobe,
  output logic [NUM_POSTED-1:0] pendWord
);
  stallState_t           state;
  logic [NUM_POSTED-1:0] waitHot;
  logic [NUM_POSTED-1:0] addrHot;
  logic                  tgtPosted;
  logic                  tgtBusy;
  logic                  launchOk;

  assign tgtPosted = wrAddr < ADDR_W'(NUM_POSTED);
  assign addrHot   = tgtPosted ? (NUM_POSTED'(1) << wrAddr) : '0;
  assign tgtBusy   = |(addrHot & pendRaw);
  assign launchOk  = wrEn && tgtPosted && (state == ST_IDLE) && !tgtBusy;

  always_comb begin
    wrReady       = !(wrEn && tgtPosted && !postEn && (state != ST_DONE));
    strobe.launch = launchOk ? addrHot : '0;
    strobe.ifWr   = wrEn && (wrAddr == ADDR_W'(IDX_IFCTRL));
    pendWord      = pendRaw & ~((state == ST_WAIT) ? waitHot : '0);
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      state   <= ST_IDLE;
      waitHot <= '0;
    end else begin
      case (state)
        ST_IDLE: if (launchOk && !postEn) begin
          state   <= ST_WAIT;
          waitHot <= addrHot;
        end
        ST_WAIT: if ((waitHot & pendRaw) == '0) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a posted launch shows in the status word one cycle later
  assert_pend_rise_R3: assert property (@(posedge busClk) disable iff (!busRstN)
    ((strobe.launch != '0) && postEn) |=>
      ((pendWord & $past(strobe.launch)) == $past(strobe.launch)));

  // R7: a stall only ends after the transfer has come back from the functional domain
  assert_stall_landed_R7: assert property (@(posedge busClk) disable iff (!busRstN)
    $fell(state == ST_WAIT) |-> ((pendRaw & $past(waitHot)) == '0));
endmodule

// File: rtl/posted_write_tracker.sv
module posted_write_tracker
  import pwt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         busClk,
  input  logic                         busRstN,
  input  logic                         fnClk,
  input  logic                         fnRstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  output logic                         wrReady,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic [DATA_W-1:0]            rdData,
  output logic [NUM_POSTED*DATA_W-1:0] fnRegs
);
  strobe_t               strobe;
  logic [NUM_POSTED-1:0] pendRaw;
  logic [NUM_POSTED-1:0] pendWord;
  logic [DATA_W-1:0]     ifCtrl;

  pwt_ctrl ctrl_i (
    .busClk(busClk), .busRstN(busRstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .pendRaw(pendRaw), .postEn(ifCtrl[POST_EN_BIT]), .wrReady(wrReady),
    .strobe(strobe), .pendWord(pendWord)
  );

  pwt_datapath #(.DATA_W(DATA_W)) data_i (
    .busClk(busClk), .busRstN(busRstN), .fnClk(fnClk), .fnRstN(fnRstN),
    .strobe(strobe), .wrData(wrData), .pendRaw(pendRaw), .ifCtrl(ifCtrl),
    .fnRegs(fnRegs)
  );

  always_comb begin
    if (rdAddr == ADDR_W'(IDX_IFCTRL))       rdData = ifCtrl;
    else if (rdAddr == ADDR_W'(IDX_PENDING)) rdData = DATA_W'(pendWord);
    else                                     rdData = '0;
  end
endmodule

// File: tb/posted_write_tracker_tb_top.sv
module posted_write_tracker_tb_top;
  localparam int BUS_PERIOD = 10;
  localparam int FN_PERIOD  = 37;
  localparam int DW         = 32;
  localparam int NREG       = 10;

  typedef struct packed {
    logic [3:0]    addr;
    logic [DW-1:0] data;
    logic [9:0]    expPend;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{4'd7, 32'hC0DE_0007, 10'h080}, '{4'd0, 32'h1234_5670, 10'h001},
    '{4'd9, 32'hFFFF_0009, 10'h200}, '{4'd2, 32'h0BAD_F002, 10'h004},
    '{4'd5, 32'h5A5A_0505, 10'h020}, '{4'd1, 32'h0000_0001, 10'h002},
    '{4'd8, 32'h8080_8080, 10'h100}, '{4'd3, 32'hDEAD_0003, 10'h008},
    '{4'd6, 32'h6006_6006, 10'h040}, '{4'd4, 32'h4444_0004, 10'h010}
  };

  logic              busClk = 0, fnClk = 0, busRstN = 0, fnRstN = 0;
  logic              wrEn = 0;
  logic [3:0]        wrAddr = '0, rdAddr = 4'd11;
  logic [DW-1:0]     wrData = '0;
  logic              wrReady;
  logic [DW-1:0]     rdData;
  logic [NREG*DW-1:0] fnRegs;

  int checks = 0;
  int fails  = 0;

  always #(BUS_PERIOD/2) busClk = ~busClk;
  always #(FN_PERIOD/2.0) fnClk = ~fnClk;

  posted_write_tracker #(.DATA_W(DW)) dut_i (
    .busClk(busClk), .busRstN(busRstN), .fnClk(fnClk), .fnRstN(fnRstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrReady(wrReady),
    .rdAddr(rdAddr), .rdData(rdData), .fnRegs(fnRegs)
  );

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] regOf(input int k);
    return fnRegs[k*DW +: DW];
  endfunction

  task automatic readAt(input logic [3:0] a, output logic [DW-1:0] d);
    rdAddr = a;
    #1;
    d = rdData;
    rdAddr = 4'd11;
  endtask

  // posted-style write: one handshake edge, ready sampled before it
  task automatic postWrite(input logic [3:0] a, input logic [DW-1:0] d, output bit rdy);
    @(negedge busClk);
    wrEn = 1; wrAddr = a; wrData = d;
    #1;
    rdy = wrReady;
    @(posedge busClk);
    #1;
    wrEn = 0;
  endtask

  // stalling write: hold the request until ready is seen
  task automatic blockWrite(input logic [3:0] a, input logic [DW-1:0] d,
                            output int stalls, output bit sawPend);
    logic [DW-1:0] st;
    @(negedge busClk);
    wrEn = 1; wrAddr = a; wrData = d;
    stalls = 0; sawPend = 0;
    #1;
    while (!wrReady && stalls < 2000) begin
      st = rdData;
      if (st[a]) sawPend = 1;
      @(negedge busClk);
      #1;
      stalls++;
    end
    @(posedge busClk);
    #1;
    wrEn = 0;
  endtask

  task automatic waitClear(input logic [9:0] mask, output bit ok);
    logic [DW-1:0] st;
    ok = 0;
    for (int n = 0; n < 500; n++) begin
      @(negedge busClk);
      readAt(4'd11, st);
      if ((st[9:0] & mask) == '0) begin ok = 1; break; end
    end
  endtask

  initial begin
    #(BUS_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    bit rdy, ok, saw;
    int stalls;

    #(BUS_PERIOD * 10 + 3);
    busRstN = 1; fnRstN = 1;

    // R1 reset state
    @(negedge busClk);
    readAt(4'd11, v); check(v == 0, "R1 pending word", v, 0);
    readAt(4'd10, v); check(v == 32'h4, "R1 ifctrl", v, 32'h4);
    check(wrReady == 1, "R1 ready", DW'(wrReady), 1);

    // table walk: R2 R3 R4 R5 on every destination register
    foreach (VECS[i]) begin
      postWrite(VECS[i].addr, VECS[i].data, rdy);
      check(rdy == 1, "R5 no stall", DW'(rdy), 1);
      @(negedge busClk);
      readAt(4'd11, v);
      check(v[9:0] == VECS[i].expPend, "R2/R3 pending bit rises", v, DW'(VECS[i].expPend));
      waitClear(VECS[i].expPend, ok);
      check(ok, "R4 pending bit falls", DW'(ok), 1);
      check(regOf(int'(VECS[i].addr)) == VECS[i].data, "R4 landed data",
            regOf(int'(VECS[i].addr)), VECS[i].data);
      readAt(VECS[i].addr, v);
      check(v == 0, "R9 destination read returns 0", v, 0);
    end

    // R6 second write while pending is dropped
    postWrite(4'd3, 32'hAAAA_0001, rdy);
    postWrite(4'd3, 32'hBBBB_0002, rdy);
    check(rdy == 1, "R6 dropped write not stalled", DW'(rdy), 1);
    waitClear(10'h008, ok);
    check(ok, "R6 pending clears", DW'(ok), 1);
    check(regOf(3) == 32'hAAAA_0001, "R6 first value kept", regOf(3), 32'hAAAA_0001);
    repeat (40) @(negedge busClk);
    readAt(4'd11, v); check(v == 0, "R6 pending not re-set", v, 0);
    check(regOf(3) == 32'hAAAA_0001, "R6 still first value", regOf(3), 32'hAAAA_0001);

    // R10 several pending at once
    postWrite(4'd0, 32'h0000_1000, rdy);
    postWrite(4'd5, 32'h0000_5000, rdy);
    postWrite(4'd9, 32'h0000_9000, rdy);
    @(negedge busClk);
    readAt(4'd11, v);
    check(v[9:0] == 10'h221, "R10 three bits pending", v, 32'h221);
    waitClear(10'h221, ok);
    check(ok, "R10 all clear", DW'(ok), 1);
    check(regOf(0) == 32'h1000 && regOf(5) == 32'h5000 && regOf(9) == 32'h9000,
          "R10 each landed", regOf(5), 32'h5000);

    // R9 status word is read-only
    postWrite(4'd11, 32'h3FF, rdy);
    check(rdy == 1, "R9 write accepted", DW'(rdy), 1);
    @(negedge busClk);
    readAt(4'd11, v); check(v == 0, "R9 pending unchanged", v, 0);

    // R11 posted write, switch to stalling, then stalling write to same register
    postWrite(4'd4, 32'h0404_0001, rdy);
    postWrite(4'd10, 32'h0, rdy);
    @(negedge busClk);
    readAt(4'd10, v); check(v == 0, "R8 ifctrl written", v, 0);
    blockWrite(4'd4, 32'h0404_0002, stalls, saw);
    check(stalls > 0, "R11 waited", DW'(stalls), 1);
    @(negedge busClk);
    check(regOf(4) == 32'h0404_0002, "R11 own data landed", regOf(4), 32'h0404_0002);

    // R7 stalling write on an idle register
    blockWrite(4'd6, 32'h7777_0006, stalls, saw);
    check(stalls > 2, "R7 ready held low", DW'(stalls), 3);
    check(!saw, "R7 no pending bit shown", DW'(saw), 0);
    @(negedge busClk);
    check(regOf(6) == 32'h7777_0006, "R7 landed at release", regOf(6), 32'h7777_0006);
    readAt(4'd11, v); check(v == 0, "R7 pending word idle", v, 0);

    // R8 restore posting; writes are posted again
    postWrite(4'd10, 32'h4, rdy);
    @(negedge busClk);
    readAt(4'd10, v); check(v == 32'h4, "R8 ifctrl readback", v, 32'h4);
    postWrite(4'd2, 32'h2222_2222, rdy);
    check(rdy == 1, "R8 posting back on", DW'(rdy), 1);
    @(negedge busClk);
    readAt(4'd11, v); check(v[9:0] == 10'h004, "R8 pending shown again", v, 32'h4);
    waitClear(10'h004, ok);
    check(ok && regOf(2) == 32'h2222_2222, "R8 landed", regOf(2), 32'h2222_2222);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule